// File: doc/BRIEF.md
# Monochrome Sprite Blitter

This block draws a small bitmap sprite into a one-bit-per-pixel frame store of 64 columns by 32 rows that it holds internally. A caller pulses `start` together with a column origin, a row origin, a row count and a base byte address. The engine then fetches one sprite byte per row from a byte-wide read port, starting at the base address and moving to the next address for each following row. Each fetched byte is spread across eight neighbouring pixels of its row and toggled into the frame store.

When the last row has been written the engine pulses `done` for one cycle. At the same moment `collision` shows whether the draw turned any lit pixel dark. The caller copies that flag into its flag register. A combinational peek port reads back any single pixel of the frame store. Arbitration of the memory and scanning of the frame store for display belong to other blocks.

Top module: `sprite_blitter`

## Requirements
- R1: After reset `busy`, `done`, `collision` and `mem_rd` are 0 and every pixel of the frame store reads 0.
- R2: A draw of n rows asserts `mem_rd` for exactly n cycles, with addresses base, base+1, ..., base+n-1 taken modulo 4096. Read data is expected on `mem_data` in the cycle after the address is presented.
- R3: Bit 7 of a sprite byte maps to the pixel at the origin column and bit 0 to the pixel seven columns to its right. In general, pixel b of a row takes bit (7-b).
- R4: A sprite bit of 1 inverts its target pixel, and a sprite bit of 0 leaves its target pixel unchanged.
- R5: `collision` is 1 after a draw exactly when at least one pixel went from 1 to 0 during that draw; otherwise it is 0.
- R6: Sprite byte k lands on frame row (origin row + k) mod 32, and its columns are (origin column + b) mod 64.
- R7: For n ≥ 1, `done` is high in the cycle that follows the (n+1)-th rising edge after the edge that accepted `start`. It stays high for exactly one cycle, and `busy` is high from acceptance through that cycle.
- R8: A row count of 0 raises `done` in the cycle right after acceptance, with `collision` 0, no memory read and no change to the frame store.
- R9: A `start` pulse while `busy` is high has no effect on the reads, the timing, the frame store or the flag of the draw in progress.
- R10: `collision` changes only at the edge that raises `done`, and holds its value until the next accepted draw completes.
- R11: `peek_pix` shows the frame-store pixel at row `peek_y`, column `peek_x`, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Draw request, accepted only while idle |
| org_x | input | 6 | Origin column |
| org_y | input | 5 | Origin row |
| rows | input | 4 | Sprite height in bytes (0..15) |
| base_addr | input | 12 | Address of the first sprite byte |
| mem_rd | output | 1 | Read strobe to sprite memory |
| mem_addr | output | 12 | Read address |
| mem_data | input | 8 | Read data, valid one cycle after the strobe |
| busy | output | 1 | Draw in progress |
| done | output | 1 | One-cycle completion pulse |
| collision | output | 1 | Result flag of the last completed draw |
| peek_x | input | 6 | Pixel read column |
| peek_y | input | 5 | Pixel read row |
| peek_pix | output | 1 | Pixel read value |

## Verification
The properties assume that the sprite memory delivers data exactly one cycle after each strobe. They also assume the draw parameters stay stable during the cycle in which `start` is accepted, and that the caller waits for `done` before depending on the frame store. The bench memory model registers data on every strobe. It drives new parameters only on falling edges, and it reads the frame store through the peek port only while the engine is idle. Random draws cover every origin, every height from 0 to 15 and arbitrary base addresses, and some of them carry a stray `start` in the middle of the draw. Directed draws cover edge wrap on both axes, address wrap, erasing redraws and single-bit sprites.

// File: rtl/blit_pkg.sv
package blit_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DRAW  = 2'd2,
    ST_FIN   = 2'd3
  } blit_state_e;
endpackage

// File: rtl/blit_rst_sync.sv
module blit_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/blit_ctrl.sv
module blit_ctrl
  import blit_pkg::*;
#(
  parameter int AW = 12,
  parameter int NW = 4,
  parameter int XW = 6,
  parameter int YW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [XW-1:0] org_x,
  input  logic [YW-1:0] org_y,
  input  logic [NW-1:0] rows,
  input  logic [AW-1:0] base_addr,
  input  logic          hit,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  output logic          busy,
  output logic          done,
  output logic          collision,
  output logic          wr_en,
  output logic [YW-1:0] wr_row,
  output logic [XW-1:0] wr_col
);
  blit_state_e   state_q, state_d;
  logic [XW-1:0] x_q;
  logic [YW-1:0] y_q;
  logic [NW-1:0] n_q;
  logic [AW-1:0] base_q;
  logic [NW-1:0] row_q, row_d;
  logic          acc_q, acc_d;
  logic          coll_q, coll_d;
  logic          cmd_ld, row_en, acc_en, coll_en;
  logic          last_row;
  logic [NW:0]   rd_idx;

  assign cmd_ld   = (state_q == ST_IDLE) && start;
  assign last_row = (row_q == n_q - NW'(1));

  // next-state logic
  always_comb begin
    state_d = state_q;
    row_d   = row_q;
    acc_d   = acc_q;
    coll_d  = coll_q;
    row_en  = 1'b0;
    acc_en  = 1'b0;
    coll_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          row_d  = '0;
          row_en = 1'b1;
          acc_d  = 1'b0;
          acc_en = 1'b1;
          if (rows == '0) begin
            state_d = ST_FIN;
            coll_d  = 1'b0;
            coll_en = 1'b1;
          end else begin
            state_d = ST_ISSUE;
          end
        end
      end
      ST_ISSUE: state_d = ST_DRAW;
      ST_DRAW: begin
        acc_d  = acc_q | hit;
        acc_en = 1'b1;
        if (last_row) begin
          state_d = ST_FIN;
          coll_d  = acc_q | hit;
          coll_en = 1'b1;
        end else begin
          row_d  = row_q + NW'(1);
          row_en = 1'b1;
        end
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      x_q     <= '0;
      y_q     <= '0;
      n_q     <= '0;
      base_q  <= '0;
      row_q   <= '0;
      acc_q   <= 1'b0;
      coll_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cmd_ld) begin
        x_q    <= org_x;
        y_q    <= org_y;
        n_q    <= rows;
        base_q <= base_addr;
      end
      if (row_en)  row_q  <= row_d;
      if (acc_en)  acc_q  <= acc_d;
      if (coll_en) coll_q <= coll_d;
    end
  end

  // fetch for row k+1 overlaps the write of row k
  assign rd_idx   = (state_q == ST_ISSUE) ? '0 : ({1'b0, row_q} + (NW+1)'(1));
  assign mem_rd   = (state_q == ST_ISSUE) || ((state_q == ST_DRAW) && !last_row);
  assign mem_addr = base_q + AW'(rd_idx);
  assign busy     = (state_q != ST_IDLE);
  assign done     = (state_q == ST_FIN);
  assign collision = coll_q;
  assign wr_en    = (state_q == ST_DRAW);
  assign wr_row   = y_q + YW'(row_q);
  assign wr_col   = x_q;
endmodule

// File: rtl/blit_rowmask.sv
module blit_rowmask #(
  parameter int FB_W = 64,
  parameter int XW   = 6,
  parameter int BW   = 8
) (
  input  logic [XW-1:0]   col0,
  input  logic [BW-1:0]   bits,
  output logic [FB_W-1:0] mask
);
  logic [FB_W-1:0] lane_vec [BW];

  for (genvar g = 0; g < BW; g++) begin : g_lane
    logic [XW-1:0] col;
    assign col         = col0 + XW'(g);
    assign lane_vec[g] = bits[BW-1-g] ? (FB_W'(1) << col) : '0;
  end

  always_comb begin
    mask = '0;
    for (int i = 0; i < BW; i++) mask = mask | lane_vec[i];
  end
endmodule

// File: rtl/blit_fb.sv
module blit_fb #(
  parameter int FB_W = 64,
  parameter int FB_H = 32,
  parameter int XW   = 6,
  parameter int YW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [YW-1:0]   wr_row,
  input  logic [FB_W-1:0] mask,
  output logic            hit,
  input  logic [XW-1:0]   peek_x,
  input  logic [YW-1:0]   peek_y,
  output logic            peek_pix
);
  logic [FB_W-1:0] fb_q [FB_H];
  logic [FB_W-1:0] cur_row;

  assign cur_row  = fb_q[wr_row];
  assign hit      = |(cur_row & mask);
  assign peek_pix = fb_q[peek_y][peek_x];

  for (genvar r = 0; r < FB_H; r++) begin : g_row
    logic row_we;
    assign row_we = wr_en && (wr_row == YW'(r));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      fb_q[r] <= '0;
      else if (row_we) fb_q[r] <= fb_q[r] ^ mask;
    end
  end
endmodule

// File: rtl/sprite_blitter.sv
module sprite_blitter #(
  parameter int FB_W = 64,
  parameter int FB_H = 32,
  parameter int AW   = 12,
  parameter int NW   = 4,
  parameter int BW   = 8,
  localparam int XW  = $clog2(FB_W),
  localparam int YW  = $clog2(FB_H)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [XW-1:0] org_x,
  input  logic [YW-1:0] org_y,
  input  logic [NW-1:0] rows,
  input  logic [AW-1:0] base_addr,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic [BW-1:0] mem_data,
  output logic          busy,
  output logic          done,
  output logic          collision,
  input  logic [XW-1:0] peek_x,
  input  logic [YW-1:0] peek_y,
  output logic          peek_pix
);
  logic            rst_n_sync;
  logic            hit;
  logic            wr_en;
  logic [YW-1:0]   wr_row;
  logic [XW-1:0]   wr_col;
  logic [FB_W-1:0] mask;

  blit_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  blit_ctrl #(.AW(AW), .NW(NW), .XW(XW), .YW(YW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .start     (start),
    .org_x     (org_x),
    .org_y     (org_y),
    .rows      (rows),
    .base_addr (base_addr),
    .hit       (hit),
    .mem_rd    (mem_rd),
    .mem_addr  (mem_addr),
    .busy      (busy),
    .done      (done),
    .collision (collision),
    .wr_en     (wr_en),
    .wr_row    (wr_row),
    .wr_col    (wr_col)
  );

  blit_rowmask #(.FB_W(FB_W), .XW(XW), .BW(BW)) u_mask (
    .col0 (wr_col),
    .bits (mem_data),
    .mask (mask)
  );

  blit_fb #(.FB_W(FB_W), .FB_H(FB_H), .XW(XW), .YW(YW)) u_fb (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .wr_en    (wr_en),
    .wr_row   (wr_row),
    .mask     (mask),
    .hit      (hit),
    .peek_x   (peek_x),
    .peek_y   (peek_y),
    .peek_pix (peek_pix)
  );
endmodule

// File: rtl/sprite_blitter_chk.sv
module sprite_blitter_chk #(
  parameter int AW = 12,
  parameter int NW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [NW-1:0] rows,
  input logic          mem_rd,
  input logic [AW-1:0] mem_addr,
  input logic          busy,
  input logic          done,
  input logic          collision
);
  logic [NW:0]   rd_cnt;
  logic [NW-1:0] n_lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_cnt <= '0;
      n_lat  <= '0;
    end else if (start && !busy) begin
      rd_cnt <= '0;
      n_lat  <= rows;
    end else if (mem_rd) begin
      rd_cnt <= rd_cnt + (NW+1)'(1);
    end
  end

  p_done_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  p_rd_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> busy);

  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && $past(mem_rd)) |-> (mem_addr == $past(mem_addr) + AW'(1)));

  p_rd_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rd_cnt == {1'b0, n_lat}));

  p_empty_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && n_lat == '0) |-> !collision);

  p_flag_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(collision) |-> done);
endmodule

bind sprite_blitter sprite_blitter_chk #(.AW(AW), .NW(NW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .rows      (rows),
  .mem_rd    (mem_rd),
  .mem_addr  (mem_addr),
  .busy      (busy),
  .done      (done),
  .collision (collision)
);

// File: tb/tb_sprite_blitter.sv
module tb_sprite_blitter;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [5:0]  org_x;
  logic [4:0]  org_y;
  logic [3:0]  rows;
  logic [11:0] base_addr;
  logic        mem_rd;
  logic [11:0] mem_addr;
  logic [7:0]  mem_data;
  logic        busy, done, collision;
  logic [5:0]  peek_x;
  logic [4:0]  peek_y;
  logic        peek_pix;

  int   total;
  int   bad;
  bit   fixed_en;
  logic [7:0] fixed_val;
  logic [7:0] salt;
  logic [63:0] fbm [32];

  sprite_blitter dut (
    .clk(clk), .rst_n(rst_n), .start(start), .org_x(org_x), .org_y(org_y),
    .rows(rows), .base_addr(base_addr), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_data(mem_data), .busy(busy), .done(done), .collision(collision),
    .peek_x(peek_x), .peek_y(peek_y), .peek_pix(peek_pix)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] hashb(input logic [11:0] a, input logic [7:0] s);
    logic [15:0] t;
    t = {4'h0, a} * 16'd157 + {8'h00, s} * 16'd29 + 16'h005a;
    return t[7:0] ^ t[13:6];
  endfunction

  function automatic logic [7:0] sprite_byte(input logic [11:0] a);
    return fixed_en ? fixed_val : hashb(a, salt);
  endfunction

  // sprite memory: one cycle of read latency
  always @(posedge clk) begin
    if (mem_rd) mem_data <= sprite_byte(mem_addr);
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare_fb(input string req);
    int mism = 0;
    for (int r = 0; r < 32; r++) begin
      for (int c = 0; c < 64; c++) begin
        peek_y = 5'(r);
        peek_x = 6'(c);
        #1;
        if (peek_pix !== fbm[r][c]) mism++;
      end
    end
    check(mism == 0, req, "frame store mismatching pixels", mism, 0);
  endtask

  task automatic run_draw(input int x, input int y, input int n, input int base,
                          input bit inject);
    int   lat = -1;
    int   rd_seen = 0;
    int   addr_bad = 0;
    logic [11:0] exp_addr;
    bit   exp_coll = 1'b0;
    logic coll_seen;

    @(negedge clk);
    start = 1'b1; org_x = 6'(x); org_y = 5'(y); rows = 4'(n); base_addr = 12'(base);
    exp_addr = 12'(base);
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (mem_rd) begin
        if (mem_addr !== exp_addr) addr_bad++;
        exp_addr = exp_addr + 12'd1;
        rd_seen++;
      end
      if (done) begin
        lat = i;
        break;
      end
      // R9: stray request with different parameters while busy
      start = inject && (i == 1);
      if (inject && i == 1) begin
        org_x = 6'(x + 9); org_y = 5'(y + 3); rows = 4'(n + 5); base_addr = 12'(base + 100);
      end
      @(negedge clk);
    end
    start = 1'b0;
    check(lat == ((n == 0) ? 0 : n + 1), inject ? "R9" : "R7", "done latency", lat,
          (n == 0) ? 0 : n + 1);
    coll_seen = collision;
    @(negedge clk);
    check(done == 1'b0, "R7", "done width", int'(done), 0);
    check(rd_seen == n && addr_bad == 0, inject ? "R9" : "R2", "read count / bad addresses",
          rd_seen * 100 + addr_bad, n * 100);

    for (int k = 0; k < n; k++) begin
      logic [7:0] b;
      int r;
      b = sprite_byte(12'(base + k));
      r = (y + k) % 32;
      for (int lane = 0; lane < 8; lane++) begin
        if (b[7 - lane]) begin
          int c;
          c = (x + lane) % 64;
          if (fbm[r][c]) exp_coll = 1'b1;
          fbm[r][c] = ~fbm[r][c];
        end
      end
    end
    check(coll_seen == exp_coll, (n == 0) ? "R8" : "R5", "collision flag",
          int'(coll_seen), int'(exp_coll));
    compare_fb("R4/R6");
    repeat (2) @(negedge clk);
    check(collision == coll_seen, "R10", "flag held while idle", int'(collision), int'(coll_seen));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
    $finish;
  end

  initial begin
    total = 0; bad = 0;
    fixed_en = 1'b0; fixed_val = 8'h00; salt = 8'h00;
    start = 1'b0; org_x = '0; org_y = '0; rows = '0; base_addr = '0;
    peek_x = '0; peek_y = '0; mem_data = 8'h00;
    for (int r = 0; r < 32; r++) fbm[r] = '0;
    void'($urandom(32'd5150));
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 / R11 reset state
    check(busy == 0 && done == 0 && collision == 0 && mem_rd == 0, "R1", "control outputs after reset",
          {busy, done, collision, mem_rd}, 0);
    compare_fb("R1/R11");

    // R3: leftmost bit at origin column
    fixed_en = 1'b1; fixed_val = 8'h80;
    run_draw(5, 3, 1, 16, 1'b0);
    peek_y = 5'd3; peek_x = 6'd5; #1;
    check(peek_pix == 1'b1, "R3", "bit7 pixel at origin", int'(peek_pix), 1);
    peek_x = 6'd6; #1;
    check(peek_pix == 1'b0, "R3", "neighbour pixel", int'(peek_pix), 0);

    // R3: rightmost bit seven columns right
    fixed_val = 8'h01;
    run_draw(0, 0, 1, 20, 1'b0);
    peek_y = 5'd0; peek_x = 6'd7; #1;
    check(peek_pix == 1'b1, "R3", "bit0 pixel at column 7", int'(peek_pix), 1);

    // R6: wrap on both axes, then R5 erase by redraw
    fixed_val = 8'hFF;
    run_draw(60, 30, 4, 40, 1'b0);
    run_draw(60, 30, 4, 40, 1'b0);

    // R8: zero rows clears the flag left by the previous erase
    run_draw(10, 10, 0, 50, 1'b0);

    // R2: address wrap at the top of memory
    fixed_en = 1'b0; salt = 8'h3c;
    run_draw(22, 7, 5, 12'hFFE, 1'b0);

    // R9: stray start mid-draw
    run_draw(33, 12, 6, 300, 1'b1);

    // random draws
    for (int t = 0; t < 40; t++) begin
      salt = 8'($urandom);
      run_draw(int'($urandom % 64), int'($urandom % 32), int'($urandom % 16),
               int'($urandom % 4096), ($urandom % 4) == 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule